// File: doc/BRIEF.md
# Conditional Branch Resolver with Static Prediction

This block settles the outcome of one conditional branch per strobe and reports the static guess for it. Each request carries a 5-bit options field, the condition bit that the issuing stage already picked out, the sign of the branch displacement and a 2-bit target kind. From these the block decides three things: whether the branch is really taken, whether the static hint said it would be taken, and whether those two disagree. Some options encodings first count down an internal count register and test the result against zero.

The count register is held inside the block and can be loaded directly at any time. Its current value is always visible on an output. All branch results are registered and appear as a one-cycle result pulse on the edge after the strobe. A branch that targets the count register and also asks for a count-down has no meaning. The block flags such a request and leaves the register untouched.

Top module: `brcond_unit`

## Requirements
- R1: After reset, res_valid, pred_taken, act_taken, mispredict and illegal_enc are 0 and ctr_value is 0. Results appear, with res_valid high for exactly one cycle, on the clock edge after a cycle in which br_valid is high. res_valid is low after any cycle without br_valid.
- R2: When br_opts[4] is 0 and br_opts[2] is 1, the branch is taken exactly when cond_bit equals br_opts[3]. Value 12 (01100) branches on a set bit and value 4 (00100) branches on a clear bit. The count register keeps its value.
- R3: When br_opts[2] is 0, the count register is first decremented by one, wrapping from 0 to all ones. With br_opts[1] = 0 the branch then needs the decremented value to be non-zero (value 16); with br_opts[1] = 1 it needs that value to be zero (value 18).
- R4: With br_opts[4] = 0 and br_opts[2] = 0, the decrement test of R3 and the condition test of R2 must both pass for the branch to be taken.
- R5: When br_opts[4] and br_opts[2] are both 1 (pattern 1z1zz, e.g. 20), the branch is always taken, it is always predicted taken, and neither cond_bit nor the count register affects it.
- R6: Bits in don't-care positions have no effect on act_taken. These are br_opts[3] when br_opts[4] is 1, br_opts[1] when br_opts[2] is 1, and br_opts[0] for pattern 1z1zz.
- R7: For tgt_kind[1] = 0 (relative or absolute target), the prediction is taken exactly when disp_neg differs from the hint bit br_opts[0]. The pattern 1z1zz is the exception (see R5).
- R8: For tgt_kind[1] = 1 (target through the link register, tgt_kind = 10, or the count register, tgt_kind = 11), the prediction equals br_opts[0]. The pattern 1z1zz is the exception (see R5).
- R9: For every non-illegal result, mispredict equals pred_taken XOR act_taken.
- R10: When tgt_kind = 11 and br_opts[2] = 0, the result has illegal_enc = 1 and pred_taken = act_taken = mispredict = 0, and the count register is not decremented.
- R11: When ctr_wr_en is high, the count register takes ctr_wr_data on that edge, even if a decrement is requested in the same cycle. The branch in that cycle is still resolved against the count value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_valid | input | 1 | Branch request strobe |
| br_opts | input | 5 | Branch options field |
| cond_bit | input | 1 | Selected condition bit |
| disp_neg | input | 1 | Displacement is negative |
| tgt_kind | input | 2 | 0x relative/absolute, 10 via link register, 11 via count register |
| ctr_wr_en | input | 1 | Direct load of the count register |
| ctr_wr_data | input | CTR_W | Value for the direct load |
| res_valid | output | 1 | Result pulse |
| pred_taken | output | 1 | Static prediction: taken |
| act_taken | output | 1 | Resolved outcome: taken |
| mispredict | output | 1 | Prediction and outcome differ |
| illegal_enc | output | 1 | Count-register target combined with decrement |
| ctr_value | output | CTR_W | Current count register |

## Verification
Every branch result and every count-register update is due on the single clock edge that follows the cycle in which the strobe or load is held. The bench drives inputs on the falling edge and holds them for one full cycle. It then compares all five result flags and ctr_value at the next falling edge, half a period after they are registered. The idle check comes one further falling edge later. The sweep crosses every options value, both condition levels, both displacement signs and all four target kinds with count seeds that make the decremented value zero, one, large or wrapped.

// File: rtl/brcond_pkg.sv
package brcond_pkg;

    localparam int OPT_W = 5;

    // Bit positions inside the options field
    localparam int OB_NOCOND = 4;  // 1: ignore condition bit
    localparam int OB_SENSE  = 3;  // wanted condition level
    localparam int OB_NODEC  = 2;  // 1: no count-down
    localparam int OB_ZSENSE = 1;  // 1: branch on zero count
    localparam int OB_HINT   = 0;  // static prediction hint

    typedef enum logic [1:0] {
        TK_DISP    = 2'b00,
        TK_DISP_AB = 2'b01,
        TK_LINK    = 2'b10,
        TK_COUNT   = 2'b11
    } tgt_kind_e;

    typedef struct packed {
        logic dec_en;
        logic zero_sense;
        logic use_cond;
        logic cond_sense;
        logic always_tk;
        logic hint;
        logic indirect;
        logic illegal;
    } br_dec_t;

    typedef struct packed {
        logic pred;
        logic act;
        logic misp;
        logic illegal;
    } br_res_t;

    function automatic logic kind_indirect(input tgt_kind_e k);
        return (k == TK_LINK) || (k == TK_COUNT);
    endfunction

endpackage

// File: rtl/brc_decode.sv
module brc_decode
    import brcond_pkg::*;
(
    input  logic [OPT_W-1:0] opts,
    input  tgt_kind_e        kind,
    output br_dec_t          dec
);
    always_comb begin
        dec            = '0;
        dec.dec_en     = ~opts[OB_NODEC];
        dec.zero_sense = opts[OB_ZSENSE];
        dec.use_cond   = ~opts[OB_NOCOND];
        dec.cond_sense = opts[OB_SENSE];
        dec.always_tk  = opts[OB_NOCOND] & opts[OB_NODEC];
        dec.hint       = opts[OB_HINT];
        dec.indirect   = kind_indirect(kind);
        dec.illegal    = (kind == TK_COUNT) & ~opts[OB_NODEC];
        if (dec.illegal) begin
            dec.dec_en = 1'b0;
        end
    end
endmodule

// File: rtl/brc_count.sv
module brc_count #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         dec_req,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] ctr_q,
    output logic         dec_zero
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] dec_val;

    always_comb begin
        dec_val  = ctr_q - ONE;
        dec_zero = (dec_val == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctr_q <= '0;
        end else if (wr_en) begin
            ctr_q <= wr_data;
        end else if (dec_req) begin
            ctr_q <= dec_val;
        end
    end
endmodule

// File: rtl/brc_resolve.sv
module brc_resolve
    import brcond_pkg::*;
(
    input  br_dec_t dec,
    input  logic    cond,
    input  logic    neg,
    input  logic    dec_zero,
    output br_res_t res
);
    logic ctr_ok;
    logic cond_ok;

    always_comb begin
        ctr_ok  = ~dec.dec_en | (dec_zero == dec.zero_sense);
        cond_ok = ~dec.use_cond | (cond == dec.cond_sense);
        res     = '0;
        if (dec.illegal) begin
            res.illegal = 1'b1;
        end else begin
            res.act = ctr_ok & cond_ok;
            if (dec.always_tk) begin
                res.pred = 1'b1;
            end else if (dec.indirect) begin
                res.pred = dec.hint;
            end else begin
                res.pred = neg ^ dec.hint;
            end
            res.misp = res.pred ^ res.act;
        end
    end
endmodule

// File: rtl/brcond_unit.sv
module brcond_unit
    import brcond_pkg::*;
#(
    parameter int CTR_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             br_valid,
    input  logic [4:0]       br_opts,
    input  logic             cond_bit,
    input  logic             disp_neg,
    input  logic [1:0]       tgt_kind,
    input  logic             ctr_wr_en,
    input  logic [CTR_W-1:0] ctr_wr_data,
    output logic             res_valid,
    output logic             pred_taken,
    output logic             act_taken,
    output logic             mispredict,
    output logic             illegal_enc,
    output logic [CTR_W-1:0] ctr_value
);
    br_dec_t dec;
    br_res_t res_d;
    br_res_t res_q;
    logic    dec_zero;
    logic    vld_q;

    brc_decode u_decode (
        .opts (br_opts),
        .kind (tgt_kind_e'(tgt_kind)),
        .dec  (dec)
    );

    brc_count #(.W(CTR_W)) u_count (
        .clk      (clk),
        .rst      (rst),
        .dec_req  (br_valid & dec.dec_en),
        .wr_en    (ctr_wr_en),
        .wr_data  (ctr_wr_data),
        .ctr_q    (ctr_value),
        .dec_zero (dec_zero)
    );

    brc_resolve u_resolve (
        .dec      (dec),
        .cond     (cond_bit),
        .neg      (disp_neg),
        .dec_zero (dec_zero),
        .res      (res_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '0;
        end else begin
            vld_q <= br_valid;
            res_q <= br_valid ? res_d : '0;
        end
    end

    assign res_valid   = vld_q;
    assign pred_taken  = res_q.pred;
    assign act_taken   = res_q.act;
    assign mispredict  = res_q.misp;
    assign illegal_enc = res_q.illegal;
endmodule

// File: rtl/brcond_chk.sv
module brcond_chk #(
    parameter int CTR_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             br_valid,
    input logic [4:0]       br_opts,
    input logic [1:0]       tgt_kind,
    input logic             ctr_wr_en,
    input logic [CTR_W-1:0] ctr_wr_data,
    input logic             res_valid,
    input logic             pred_taken,
    input logic             act_taken,
    input logic             mispredict,
    input logic             illegal_enc,
    input logic [CTR_W-1:0] ctr_value
);
    logic bad_req;
    assign bad_req = (tgt_kind == 2'b11) && !br_opts[2];

    AST_IDLE_NO_RESULT: assert property (@(posedge clk) disable iff (rst)
        !br_valid |=> !res_valid); // R1

    AST_NODEC_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (br_valid && br_opts[2] && !ctr_wr_en) |=> $stable(ctr_value)); // R2

    AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (rst)
        (br_valid && !br_opts[2] && !bad_req && !ctr_wr_en)
        |=> ctr_value == CTR_W'($past(ctr_value) - 1'b1)); // R3

    AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (br_valid && br_opts[4] && br_opts[2]) |=> (act_taken && pred_taken)); // R5

    AST_MISP_XOR: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !illegal_enc) |-> (mispredict == (pred_taken ^ act_taken))); // R9

    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (rst)
        (br_valid && bad_req && !ctr_wr_en)
        |=> (illegal_enc && !act_taken && !pred_taken && $stable(ctr_value))); // R10

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        ctr_wr_en |=> ctr_value == $past(ctr_wr_data)); // R11
endmodule

bind brcond_unit brcond_chk #(.CTR_W(CTR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .br_valid    (br_valid),
    .br_opts     (br_opts),
    .tgt_kind    (tgt_kind),
    .ctr_wr_en   (ctr_wr_en),
    .ctr_wr_data (ctr_wr_data),
    .res_valid   (res_valid),
    .pred_taken  (pred_taken),
    .act_taken   (act_taken),
    .mispredict  (mispredict),
    .illegal_enc (illegal_enc),
    .ctr_value   (ctr_value)
);

// File: tb/brcond_unit_tb.sv
`timescale 1ns/1ps
module brcond_unit_tb;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst;
    logic         br_valid;
    logic [4:0]   br_opts;
    logic         cond_bit;
    logic         disp_neg;
    logic [1:0]   tgt_kind;
    logic         ctr_wr_en;
    logic [W-1:0] ctr_wr_data;
    logic         res_valid, pred_taken, act_taken, mispredict, illegal_enc;
    logic [W-1:0] ctr_value;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    brcond_unit #(.CTR_W(W)) u_dut (
        .clk(clk), .rst(rst), .br_valid(br_valid), .br_opts(br_opts),
        .cond_bit(cond_bit), .disp_neg(disp_neg), .tgt_kind(tgt_kind),
        .ctr_wr_en(ctr_wr_en), .ctr_wr_data(ctr_wr_data),
        .res_valid(res_valid), .pred_taken(pred_taken), .act_taken(act_taken),
        .mispredict(mispredict), .illegal_enc(illegal_enc), .ctr_value(ctr_value)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Independent reference built from the requirement text
    task automatic model(input logic [4:0] o, input logic c, input logic n,
                         input logic [1:0] k, input logic [W-1:0] cv,
                         output logic ea, output logic ep, output logic ei,
                         output logic [W-1:0] ec);
        logic counting, cpass, qpass;
        logic [W-1:0] nv;
        counting = (o[2] == 1'b0);
        ei = (k == 2'b11) && counting;
        nv = cv - 1;
        if (ei) begin
            ea = 0; ep = 0; ec = cv;
        end else begin
            if (!counting)  cpass = 1;
            else if (o[1])  cpass = (nv == 0);
            else            cpass = (nv != 0);
            qpass = o[4] ? 1'b1 : (c == o[3]);
            ea = cpass && qpass;
            if (o[4] && o[2])  ep = 1;
            else if (k[1])     ep = o[0];
            else               ep = (n != o[0]);
            ec = counting ? nv : cv;
        end
    endtask

    task automatic idle();
        br_valid = 0; ctr_wr_en = 0; br_opts = 0; cond_bit = 0;
        disp_neg = 0; tgt_kind = 0; ctr_wr_data = 0;
    endtask

    task automatic load(input logic [W-1:0] v);
        @(negedge clk);
        idle();
        ctr_wr_en = 1; ctr_wr_data = v;
        @(negedge clk);
        ctr_wr_en = 0;
    endtask

    // Issue at current negedge, results checked one negedge later
    task automatic issue(input logic [4:0] o, input logic c, input logic n, input logic [1:0] k);
        br_valid = 1; br_opts = o; cond_bit = c; disp_neg = n; tgt_kind = k;
        @(negedge clk);
        br_valid = 0;
    endtask

    function automatic string cls(input logic [4:0] o, input logic [1:0] k);
        if (k == 2'b11 && !o[2]) return "R10";
        if (o[4] && o[2])        return "R5";
        if (!o[2] && !o[4])      return "R4";
        if (!o[2])               return "R3";
        return "R2";
    endfunction

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog timeout actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic ea, ep, ei;
        logic [W-1:0] ec, seed;
        logic a20, a31, a22;
        idle();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check("R1 reset res_valid", W'(res_valid), 0);
        check("R1 reset flags", W'({pred_taken, act_taken, mispredict, illegal_enc}), 0);
        check("R1 reset count", ctr_value, 0);

        for (int s = 0; s < 4; s++) begin
            seed = (s == 0) ? 0 : (s == 1) ? 1 : (s == 2) ? 2 : 32'h8000_0000;
            for (int oi = 0; oi < 32; oi++) begin
                for (int ki = 0; ki < 4; ki++) begin
                    for (int ci = 0; ci < 2; ci++) begin
                        for (int ni = 0; ni < 2; ni++) begin
                            load(seed);
                            model(5'(oi), 1'(ci), 1'(ni), 2'(ki), seed, ea, ep, ei, ec);
                            issue(5'(oi), 1'(ci), 1'(ni), 2'(ki));
                            check("R1 res_valid", W'(res_valid), 1);
                            check({cls(5'(oi), 2'(ki)), " act_taken"}, W'(act_taken), W'(ea));
                            check(ki[1] ? "R8 pred_taken" : "R7 pred_taken", W'(pred_taken), W'(ep));
                            check("R9 mispredict", W'(mispredict), W'(ei ? 1'b0 : (ep ^ ea)));
                            check("R10 illegal_enc", W'(illegal_enc), W'(ei));
                            check({cls(5'(oi), 2'(ki)), " count"}, ctr_value, ec);
                        end
                    end
                end
            end
        end

        // R1: result pulse lasts one cycle
        load(5);
        issue(5'd12, 1, 0, 2'b00);
        @(negedge clk);
        check("R1 idle res_valid", W'(res_valid), 0);

        // R6: don't-care bits of the always pattern
        load(1);
        issue(5'd20, 0, 0, 2'b00); a20 = act_taken;
        issue(5'd31, 0, 0, 2'b00); a31 = act_taken;
        issue(5'd22, 0, 0, 2'b00); a22 = act_taken;
        check("R6 z bits 20 vs 31", W'(a31), W'(a20));
        check("R6 z bits 20 vs 22", W'(a22), W'(a20));
        // R6: z bit 3 with bit4 set, decrement pattern
        load(3); issue(5'd16, 0, 0, 2'b00); a20 = act_taken;
        load(3); issue(5'd24, 1, 0, 2'b00); a31 = act_taken;
        check("R6 z bit3 in 1z00y", W'(a31), W'(a20));

        // R3 wrap from zero
        load(0);
        issue(5'd16, 0, 0, 2'b00);
        check("R3 wrap count", ctr_value, 32'hFFFF_FFFF);
        check("R3 wrap taken", W'(act_taken), 1);

        // R11 write beats decrement; branch uses old count (10-1=9, nonzero)
        load(10);
        ctr_wr_en = 1; ctr_wr_data = 77;
        issue(5'd16, 0, 0, 2'b00);
        ctr_wr_en = 0;
        check("R11 write wins", ctr_value, 77);
        check("R11 old count used", W'(act_taken), 1);
        load(1);
        ctr_wr_en = 1; ctr_wr_data = 500;
        issue(5'd18, 0, 0, 2'b00);
        ctr_wr_en = 0;
        check("R11 write wins zero test", ctr_value, 500);
        check("R11 old count zero taken", W'(act_taken), 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule